// File: doc/BRIEF.md
# Turbo Tail-Bit Output Sequencer

This block sits behind the two constituent encoders of a turbo encoder. One encoder sees the block in natural order and the other sees it interleaved. The block takes one systematic bit and one parity bit from each encoder per step. It forms the coded output stream, with a valid flag and one tail flag for each encoder. After the last data bit it terminates the encoders in turn: encoder 1 for three steps, then encoder 2 for three steps. It tells the encoders which of them must run its termination, and when they may advance.

A mode input is sampled with the start pulse and chooses how the 12 tail bits leave:
- **Parallel mode** spends six output cycles on them. The systematic tail bits of encoder 2 take over the encoder-1 systematic port.
- **Packed mode** repacks them into four output cycles over three ports. A small tail buffer and a fixed three-stage output pipeline give the buffer time to collect the late tail bits before they are due.

A downstream ready input freezes the outputs and all internal progress. A done pulse marks the acceptance of the final tail cycle, so that the upstream symbol buffer can release its bank.

Top module: `turbo_tail_sequencer`

## Requirements
- R1: After reset, outValid, outTail1, outTail2, blockDone, encStep, term1 and term2 are all low.
- R2: Data symbol i appears on the output with outSys1 = encoder-1 systematic, outPar1 = encoder-1 parity, outPar2 = encoder-2 parity and outSys2 = encoder-2 systematic. It appears three accepted (ready-high) cycles after the encoders present it.
- R3: The encoders present step k on the cycle encStep is high. encStep is high only while a block is in progress and dnReady is high. term1 is high for steps n..n+2 and term2 for steps n+3..n+5, where n is the block length.
- R4: In parallel mode, tail cycles 0..2 carry {outSys1, outPar1} = encoder-1 {systematic, parity} with outPar2 = outSys2 = 0. Tail cycles 3..5 carry outSys1 = outSys2 = encoder-2 systematic, outPar2 = encoder-2 parity and outPar1 = 0.
- R5: In packed mode, the tail order is x1,z1,x2,z2,x3,z3 from encoder 1, then x'1,z'1,x'2,z'2,x'3,z'3 from encoder 2. Output tail cycle s carries sequence bits 3s, 3s+1 and 3s+2 on outSys1, outPar1 and outPar2 in that order, with outSys2 = 0.
- R6: outValid is high for exactly n+4 accepted cycles in packed mode and n+6 in parallel mode. Once high for a block, it stays high until the last tail cycle.
- R7: In packed mode outTail1 is high for tail cycles 0..1 and outTail2 for 2..3. In parallel mode outTail1 is high for 0..2 and outTail2 for 3..5. The two flags are never high together.
- R8: While dnReady is low, all outputs keep their values and no encoder step is taken.
- R9: blockDone is high exactly in the cycle in which the last tail cycle is on the output and dnReady is high.
- R10: startOut is accepted only while no block is in progress. Block length and mode are sampled at acceptance, and a start pulse during a block has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| startOut | input | 1 | Start of a block's output, accepted when idle |
| muxMode | input | 1 | 1 = packed tail (4 cycles), 0 = parallel tail (6 cycles) |
| blockLen | input | LEN_W | Number of data bits in the block |
| dnReady | input | 1 | Downstream ready; low freezes the block |
| enc1Sys | input | 1 | Encoder 1 systematic bit |
| enc1Par | input | 1 | Encoder 1 parity bit |
| enc2Sys | input | 1 | Encoder 2 systematic bit |
| enc2Par | input | 1 | Encoder 2 parity bit |
| encStep | output | 1 | Encoders advance one step at this edge |
| term1 | output | 1 | Encoder 1 runs termination this step |
| term2 | output | 1 | Encoder 2 runs termination this step |
| outSys1 | output | 1 | Encoder-1 systematic port |
| outPar1 | output | 1 | Encoder-1 parity port |
| outPar2 | output | 1 | Encoder-2 parity port |
| outSys2 | output | 1 | Encoder-2 systematic port |
| outValid | output | 1 | Output ports carry a valid symbol |
| outTail1 | output | 1 | Encoder-1 tail bits on the output |
| outTail2 | output | 1 | Encoder-2 tail bits on the output |
| blockDone | output | 1 | Last tail cycle accepted |

## Verification
In packed mode, the edge that captures the last pair of encoder-2 tail bits is the same edge that moves tail cycle 3 to the output. That cycle must therefore show z'(n+3) read from a buffer written at that very edge. The bench provokes this with randomly stalled dnReady around the tail and with short blocks. A scoreboard compares every accepted output against items derived from the encoder bits the bench supplied. The drain of one block can also coincide with the start and first data steps of the next. Blocks are therefore launched as soon as the source side is free, and the valid count and done pulse of each block are checked.

// File: rtl/tailseq_pkg.sv
package tailseq_pkg;

  // Which encoder bits feed the output lanes for the current step
  typedef enum logic [1:0] {
    SEL_DATA  = 2'd0,
    SEL_TERM1 = 2'd1,
    SEL_TERM2 = 2'd2,
    SEL_NONE  = 2'd3
  } laneSel_e;

  // Strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic       advance;   // downstream accepted, everything moves
    logic       valid;
    logic       tail1;
    logic       tail2;
    logic       last;
    logic       muxSlot;   // entry is a packed tail slot, data comes from buffer
    logic [1:0] slot;
    laneSel_e   sel;
    logic       capture;   // store this step's tail pair
    logic [2:0] capIdx;    // tail step index 0..5
  } strobe_t;

  // One pipeline stage of the output path
  typedef struct packed {
    logic       valid;
    logic       tail1;
    logic       tail2;
    logic       last;
    logic       muxSlot;
    logic [1:0] slot;
    logic       sys1;
    logic       par1;
    logic       par2;
    logic       sys2;
  } stage_t;

endpackage

// File: rtl/tailseq_ctrl.sv
module tailseq_ctrl
  import tailseq_pkg::*;
#(
  parameter int LEN_W      = 13,
  parameter int TAIL_STEPS = 6,
  parameter int MUX_SLOTS  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startOut,
  input  logic             muxMode,
  input  logic [LEN_W-1:0] blockLen,
  input  logic             ready,
  output strobe_t          strb,
  output logic             encStep,
  output logic             term1,
  output logic             term2
);

  localparam int STEP_W   = LEN_W + 1;
  localparam int HALF     = TAIL_STEPS / 2;
  localparam int MUX_HALF = MUX_SLOTS / 2;

  logic              active;
  logic              muxReg;
  logic [LEN_W-1:0]  lenReg;
  logic [STEP_W-1:0] step;
  logic [STEP_W-1:0] tailPos;
  logic [2:0]        pos;
  logic              inTail;
  logic              lastStep;

  assign tailPos  = step - {1'b0, lenReg};
  assign inTail   = step >= {1'b0, lenReg};
  assign pos      = tailPos[2:0];
  assign lastStep = inTail && (pos == 3'(TAIL_STEPS - 1));

  assign encStep = active && ready;
  assign term1   = active && inTail && (pos < 3'(HALF));
  assign term2   = active && inTail && (pos >= 3'(HALF));

  always_comb begin
    strb         = '0;
    strb.advance = ready;
    strb.capture = active && inTail;
    strb.capIdx  = pos;
    strb.slot    = pos[1:0];
    if (!active) begin
      strb.sel = SEL_NONE;
    end else if (!inTail) begin
      strb.sel   = SEL_DATA;
      strb.valid = 1'b1;
    end else if (muxReg) begin
      strb.sel     = SEL_NONE;
      strb.valid   = pos < 3'(MUX_SLOTS);
      strb.muxSlot = pos < 3'(MUX_SLOTS);
      strb.tail1   = pos < 3'(MUX_HALF);
      strb.tail2   = (pos >= 3'(MUX_HALF)) && (pos < 3'(MUX_SLOTS));
      strb.last    = pos == 3'(MUX_SLOTS - 1);
    end else begin
      strb.sel   = (pos < 3'(HALF)) ? SEL_TERM1 : SEL_TERM2;
      strb.valid = 1'b1;
      strb.tail1 = pos < 3'(HALF);
      strb.tail2 = pos >= 3'(HALF);
      strb.last  = lastStep;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      muxReg <= 1'b0;
      lenReg <= '0;
      step   <= '0;
    end else if (!active && startOut) begin
      active <= 1'b1;
      muxReg <= muxMode;
      lenReg <= blockLen;
      step   <= '0;
    end else if (active && ready) begin
      step <= step + 1'b1;
      if (lastStep) active <= 1'b0;
    end
  end

  // R3
  term_handover_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(term1) |-> term2);

  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (active && startOut) |=> ($stable(lenReg) && $stable(muxReg)));

endmodule

// File: rtl/tailseq_dp.sv
module tailseq_dp
  import tailseq_pkg::*;
#(
  parameter int TAIL_STEPS = 6,
  parameter int MUX_SLOTS  = 4
) (
  input  logic    clk,
  input  logic    rst,
  input  strobe_t strb,
  input  logic    enc1Sys,
  input  logic    enc1Par,
  input  logic    enc2Sys,
  input  logic    enc2Par,
  output logic    outSys1,
  output logic    outPar1,
  output logic    outPar2,
  output logic    outSys2,
  output logic    outValid,
  output logic    outTail1,
  output logic    outTail2,
  output logic    blockDone
);

  localparam int TAIL_BITS  = 2 * TAIL_STEPS;
  localparam int SLOT_BITS  = TAIL_BITS / MUX_SLOTS;
  // deep enough that the last tail pair is stored when the last slot leaves
  localparam int PIPE_DEPTH = TAIL_STEPS - MUX_SLOTS + 1;
  localparam int HALF       = TAIL_STEPS / 2;

  stage_t               entry;
  stage_t               pipe [PIPE_DEPTH];
  stage_t               head;
  logic [TAIL_BITS-1:0] tailBuf;
  logic [SLOT_BITS-1:0] slotBits [MUX_SLOTS];

  always_comb begin
    entry         = '0;
    entry.valid   = strb.valid;
    entry.tail1   = strb.tail1;
    entry.tail2   = strb.tail2;
    entry.last    = strb.last;
    entry.muxSlot = strb.muxSlot;
    entry.slot    = strb.slot;
    case (strb.sel)
      SEL_DATA: begin
        entry.sys1 = enc1Sys;
        entry.par1 = enc1Par;
        entry.par2 = enc2Par;
        entry.sys2 = enc2Sys;
      end
      SEL_TERM1: begin
        entry.sys1 = enc1Sys;
        entry.par1 = enc1Par;
      end
      SEL_TERM2: begin
        entry.sys1 = enc2Sys;   // encoder-2 systematic tail replaces port
        entry.par2 = enc2Par;
        entry.sys2 = enc2Sys;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PIPE_DEPTH; i++) pipe[i] <= '0;
    end else if (strb.advance) begin
      pipe[0] <= entry;
      for (int i = 1; i < PIPE_DEPTH; i++) pipe[i] <= pipe[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tailBuf <= '0;
    end else if (strb.advance && strb.capture) begin
      for (int p = 0; p < TAIL_STEPS; p++) begin
        if (strb.capIdx == 3'(p)) begin
          tailBuf[2*p]   <= (p < HALF) ? enc1Sys : enc2Sys;
          tailBuf[2*p+1] <= (p < HALF) ? enc1Par : enc2Par;
        end
      end
    end
  end

  for (genvar s = 0; s < MUX_SLOTS; s++) begin : g_slot
    assign slotBits[s] = tailBuf[SLOT_BITS*s +: SLOT_BITS];
  end

  assign head      = pipe[PIPE_DEPTH-1];
  assign outSys1   = head.muxSlot ? slotBits[head.slot][0] : head.sys1;
  assign outPar1   = head.muxSlot ? slotBits[head.slot][1] : head.par1;
  assign outPar2   = head.muxSlot ? slotBits[head.slot][2] : head.par2;
  assign outSys2   = head.muxSlot ? 1'b0 : head.sys2;
  assign outValid  = head.valid;
  assign outTail1  = head.tail1;
  assign outTail2  = head.tail2;
  assign blockDone = head.valid && head.last && strb.advance;

  // R8
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.advance |=> $stable({outSys1, outPar1, outPar2, outSys2,
                               outValid, outTail1, outTail2}));

  // R6
  valid_run_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !head.last && strb.advance) |=> outValid);

  // R7
  tail_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({outTail1, outTail2}));

  // R9
  done_tail_chk: assert property (@(posedge clk) disable iff (rst)
    blockDone |-> (outValid && outTail2));

endmodule

// File: rtl/turbo_tail_sequencer.sv
module turbo_tail_sequencer
  import tailseq_pkg::*;
#(
  parameter int LEN_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startOut,
  input  logic             muxMode,
  input  logic [LEN_W-1:0] blockLen,
  input  logic             dnReady,
  input  logic             enc1Sys,
  input  logic             enc1Par,
  input  logic             enc2Sys,
  input  logic             enc2Par,
  output logic             encStep,
  output logic             term1,
  output logic             term2,
  output logic             outSys1,
  output logic             outPar1,
  output logic             outPar2,
  output logic             outSys2,
  output logic             outValid,
  output logic             outTail1,
  output logic             outTail2,
  output logic             blockDone
);

  localparam int TAIL_STEPS = 6;
  localparam int MUX_SLOTS  = 4;

  strobe_t strb;

  tailseq_ctrl #(
    .LEN_W(LEN_W), .TAIL_STEPS(TAIL_STEPS), .MUX_SLOTS(MUX_SLOTS)
  ) u_ctrl (
    .clk(clk), .rst(rst), .startOut(startOut), .muxMode(muxMode),
    .blockLen(blockLen), .ready(dnReady), .strb(strb),
    .encStep(encStep), .term1(term1), .term2(term2)
  );

  tailseq_dp #(
    .TAIL_STEPS(TAIL_STEPS), .MUX_SLOTS(MUX_SLOTS)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb),
    .enc1Sys(enc1Sys), .enc1Par(enc1Par), .enc2Sys(enc2Sys), .enc2Par(enc2Par),
    .outSys1(outSys1), .outPar1(outPar1), .outPar2(outPar2), .outSys2(outSys2),
    .outValid(outValid), .outTail1(outTail1), .outTail2(outTail2),
    .blockDone(blockDone)
  );

endmodule

// File: tb/tb_turbo_tail_sequencer.sv
module tb_turbo_tail_sequencer;

  localparam int LEN_W = 13;

  typedef struct packed {
    logic sys1, par1, par2, sys2, tail1, tail2, last;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic startOut = 1'b0, muxMode = 1'b0, dnReady = 1'b1;
  logic [LEN_W-1:0] blockLen = '0;
  logic enc1Sys = 1'b0, enc1Par = 1'b0, enc2Sys = 1'b0, enc2Par = 1'b0;
  logic encStep, term1, term2, outSys1, outPar1, outPar2, outSys2;
  logic outValid, outTail1, outTail2, blockDone;

  turbo_tail_sequencer #(.LEN_W(LEN_W)) dut (.*);

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0, running = 0, rndReady = 0, stepPending = 0, moreDue = 0;
  int srcLen = 0, srcIdx = 6, acceptCnt = 0;
  bit tabX [0:255], tabZ [0:255], tabXp [0:255], tabZp [0:255];
  item_t expQ [$];
  string tagQ [$];
  int    lenQ [$];
  logic [6:0] heldOut;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-cycle source driver and monitor
  initial begin
    forever begin
      @(negedge clk);
      if (running) begin
        if (stepPending) srcIdx++;
        dnReady = rndReady ? ($urandom % 4 != 0) : 1'b1;
        if (srcIdx < 256) begin
          enc1Sys = tabX[srcIdx];  enc1Par = tabZ[srcIdx];
          enc2Sys = tabXp[srcIdx]; enc2Par = tabZp[srcIdx];
        end
        #1;
        stepPending = encStep;
        if (encStep) begin
          // R3 termination order per step
          check(term1 == (srcIdx >= srcLen && srcIdx < srcLen + 3), "R3 term1", term1, srcIdx);
          check(term2 == (srcIdx >= srcLen + 3 && srcIdx < srcLen + 6), "R3 term2", term2, srcIdx);
        end
        if (!dnReady) check(encStep == 1'b0, "R8 step", encStep, 0);
        if (heldOut[0]) ; // placeholder bit use avoided below
        begin : freezeBlk
          logic [6:0] nowOut;
          nowOut = {outSys1, outPar1, outPar2, outSys2, outValid, outTail1, outTail2};
          if (moreDue === 1'b1 && 0) ;
          if (heldValid) check(nowOut == heldOut, "R8 freeze", nowOut, heldOut);
          heldValid = !dnReady;
          heldOut = nowOut;
        end
        if (dnReady) begin
          if (outValid) begin
            if (expQ.size() == 0) begin
              check(0, "R6 extra valid", 1, 0);
            end else begin
              item_t e;
              string t;
              e = expQ.pop_front();
              t = tagQ.pop_front();
              acceptCnt++;
              check({outSys1, outPar1, outPar2, outSys2} == {e.sys1, e.par1, e.par2, e.sys2},
                    t, {outSys1, outPar1, outPar2, outSys2}, {e.sys1, e.par1, e.par2, e.sys2});
              check({outTail1, outTail2} == {e.tail1, e.tail2}, "R7 tail flags",
                    {outTail1, outTail2}, {e.tail1, e.tail2});
              check(blockDone == e.last, "R9 done", blockDone, e.last);
              moreDue = !e.last;
              if (e.last) begin
                int l;
                l = lenQ.pop_front();
                check(acceptCnt == l, "R6 valid count", acceptCnt, l);
                acceptCnt = 0;
              end
            end
          end else begin
            check(blockDone == 1'b0, "R9 done idle", blockDone, 0);
            if (moreDue) check(0, "R6 valid gap", 0, 1);
          end
        end
      end
    end
  end

  bit heldValid = 0;

  task automatic startBlock(input int n, input bit mux, input bit rnd);
    bit seq [12];
    item_t it;
    do begin @(negedge clk); #2; end while (srcIdx < srcLen + 6);
    for (int i = 0; i < n + 6; i++) begin
      tabX[i] = 1'($urandom); tabZ[i] = 1'($urandom);
      tabXp[i] = 1'($urandom); tabZp[i] = 1'($urandom);
    end
    for (int i = 0; i < n; i++) begin
      it = '{tabX[i], tabZ[i], tabZp[i], tabXp[i], 1'b0, 1'b0, 1'b0};
      expQ.push_back(it); tagQ.push_back("R2 data");
    end
    if (!mux) begin
      for (int p = 0; p < 6; p++) begin
        int i = n + p;
        if (p < 3) it = '{tabX[i], tabZ[i], 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
        else       it = '{tabXp[i], 1'b0, tabZp[i], tabXp[i], 1'b0, 1'b1, 1'(p == 5)};
        expQ.push_back(it); tagQ.push_back("R4 parallel tail");
      end
      lenQ.push_back(n + 6);
    end else begin
      for (int p = 0; p < 6; p++) begin
        seq[2*p]   = (p < 3) ? tabX[n+p] : tabXp[n+p];
        seq[2*p+1] = (p < 3) ? tabZ[n+p] : tabZp[n+p];
      end
      for (int s = 0; s < 4; s++) begin
        it = '{seq[3*s], seq[3*s+1], seq[3*s+2], 1'b0, 1'(s < 2), 1'(s >= 2), 1'(s == 3)};
        expQ.push_back(it); tagQ.push_back("R5 packed tail");
      end
      lenQ.push_back(n + 4);
    end
    rndReady = rnd;
    srcLen = n; srcIdx = 0; stepPending = 0;
    blockLen = LEN_W'(n); muxMode = mux; startOut = 1'b1;
    @(negedge clk); #2;
    startOut = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check({outValid, outTail1, outTail2, blockDone, encStep, term1, term2} == 7'b0,
          "R1 reset", {outValid, outTail1, outTail2, blockDone, encStep, term1, term2}, 0);
    rst = 1'b0;
    @(negedge clk); #2;
    check({outValid, outTail1, outTail2, blockDone, encStep} == 5'b0, "R1 idle", outValid, 0);
    running = 1;
    startBlock(5, 1'b0, 1'b0);
    startBlock(5, 1'b1, 1'b0);
    startBlock(1, 1'b1, 1'b0);
    startBlock(1, 1'b0, 1'b1);
    startBlock(40, 1'b0, 1'b1);
    startBlock(40, 1'b1, 1'b1);
    // R10: a start pulse mid-block with other length and mode is ignored
    repeat (4) @(negedge clk);
    #2; blockLen = 7; muxMode = 1'b0; startOut = 1'b1;
    @(negedge clk); #2; startOut = 1'b0;
    for (int b = 0; b < 12; b++) startBlock(1 + ($urandom % 60), 1'($urandom), 1'($urandom));
    for (int w = 0; w < 2000 && expQ.size() != 0; w++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R6 drained", expQ.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule